// File: doc/BRIEF.md
# Summation Frame Slave Extractor

This block sits on the downstream path of a slave node in a chain of nodes joined in a line. Every frame that travels down the chain carries one segment per node, so a single pass refreshes every node. The block runs two paths on the same byte stream at the same time. The repeat path passes every byte and its frame markers to the next node, unchanged, through a fixed two-register delay. The analysis path walks the segment list and picks out the segments whose id equals this node's id. It writes their payload into a dual-port data RAM and a descriptor of each one into a dual-port descriptor RAM.

A segment is laid out as one id byte, a 16-bit length sent high byte first, and then that many payload bytes. An id of 0xFF ends the list. When a frame ends cleanly, a completion strobe holds high for a fixed window of twelve clocks. If a frame stops partway through a segment, an error flag is raised instead. Local logic reads both RAMs through their own read ports.

Top module: `sfx_node_extract`

## Requirements
- R1: Each byte accepted on the input, together with its valid, start and end markers, appears unchanged on the output two clocks later. The byte sampled at edge k is visible after edge k+1. During reset the output valid is 0.
- R2: While reset is high and right after it, out_valid, done_strobe and err_flag are 0.
- R3: A frame starts at the byte marked start. Its first byte is an id. Each segment is id, length high byte, length low byte, then length payload bytes. Payload bytes of every segment whose id equals node_id go to the data RAM at consecutive addresses, starting from address 0 in each frame.
- R4: For the k-th matching segment of a frame (k from 0), descriptor entry k receives {start address in the data RAM (DATA_AW bits), length (16 bits)}, with the length in bits 15:0. The entry is written when the length low byte is taken.
- R5: A segment whose id differs from node_id writes neither RAM, so earlier contents stay readable.
- R6: An id byte of 0xFF ends the list. Bytes that follow it in the same frame write nothing, even if they look like a matching segment. A node_id of 0xFF never matches.
- R7: When the end byte of a well-formed frame is sampled, done_strobe is high after that edge for exactly 12 clocks. A frame is well formed if it ends at a segment boundary or after the 0xFF terminator.
- R8: A frame that ends inside a segment header or payload sets err_flag after its end byte and gives no done_strobe. err_flag stays set until the start byte of the next frame is sampled.
- R9: A segment of length 0 writes its descriptor entry with length 0 and no payload, and parsing continues with the next id byte.
- R10: Both RAM read ports return the word at the given address one clock after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| node_id | input | 8 | This node's assigned sequence number |
| in_valid | input | 1 | Input byte valid |
| in_sof | input | 1 | Input byte is first of frame |
| in_eof | input | 1 | Input byte is last of frame |
| in_data | input | 8 | Input byte |
| out_valid | output | 1 | Repeated byte valid |
| out_sof | output | 1 | Repeated start marker |
| out_eof | output | 1 | Repeated end marker |
| out_data | output | 8 | Repeated byte |
| done_strobe | output | 1 | Twelve-clock completion window |
| err_flag | output | 1 | Last frame was truncated |
| app_rd_addr | input | DATA_AW | Data RAM read address |
| app_rd_data | output | 8 | Data RAM read word |
| meta_rd_addr | input | META_AW | Descriptor RAM read address |
| meta_rd_data | output | DATA_AW+16 | Descriptor RAM read word |

## Verification
The bench targets several corner cases:
- Zero-length segments. A parser that waits for a payload byte would swallow the next id.
- Several matches in one frame. Wrong pointer handling would overwrite the first payload or put the wrong start address in the second descriptor.
- A matching-looking segment placed after the 0xFF terminator. It would corrupt earlier RAM contents if the terminator were not honoured.
- Frames cut short inside a header or a payload. A weak end check would fire the strobe or leave the flag clear.

Throughout, the repeat path is compared byte for byte with the input seen two edges earlier. This exposes any extra or missing stage and any change to a forwarded byte.

// File: rtl/sfx_pkg.sv
package sfx_pkg;

    localparam logic [7:0] LIST_END_ID = 8'hFF;

    typedef enum logic [2:0] {
        PS_IDLE,
        PS_ID,
        PS_LEN_HI,
        PS_LEN_LO,
        PS_BODY,
        PS_TAIL
    } parse_state_t;

    typedef struct packed {
        logic       vld;
        logic       sof;
        logic       eof;
        logic [7:0] dat;
    } beat_t;

    function automatic logic [15:0] seg_length(input logic [7:0] hi, input logic [7:0] lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/sfx_dpram.sv
module sfx_dpram #(
    parameter int AW = 6,
    parameter int W  = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/sfx_fwd_pipe.sv
module sfx_fwd_pipe
    import sfx_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t din,
    output beat_t dout
);
    beat_t [STAGES-1:0] pipe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe_q <= '0;
        end else begin
            pipe_q[0] <= din;
            for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign dout = pipe_q[STAGES-1];
endmodule

// File: rtl/sfx_seg_parser.sv
module sfx_seg_parser
    import sfx_pkg::*;
#(
    parameter int DATA_AW = 6,
    parameter int META_AW = 2,
    localparam int META_W = DATA_AW + 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [7:0]         node_id,
    input  beat_t              din,
    output logic               data_we,
    output logic [DATA_AW-1:0] data_waddr,
    output logic [7:0]         data_wdata,
    output logic               meta_we,
    output logic [META_AW-1:0] meta_waddr,
    output logic [META_W-1:0]  meta_wdata,
    output logic               frame_start,
    output logic               frame_good,
    output logic               frame_short
);
    parse_state_t       st_q, st_d, st_eff;
    logic               hit_q, hit_d;
    logic [7:0]         lhi_q, lhi_d;
    logic [15:0]        rem_q, rem_d;
    logic [DATA_AW-1:0] ptr_q, ptr_d, ptr_eff;
    logic [META_AW-1:0] mix_q, mix_d, mix_eff;
    logic [15:0]        len_now;

    always_comb begin
        st_eff  = (din.vld && din.sof) ? PS_ID : st_q;
        ptr_eff = (din.vld && din.sof) ? '0 : ptr_q;
        mix_eff = (din.vld && din.sof) ? '0 : mix_q;
        len_now = seg_length(lhi_q, din.dat);

        st_d  = st_q;
        hit_d = hit_q;
        lhi_d = lhi_q;
        rem_d = rem_q;
        ptr_d = ptr_q;
        mix_d = mix_q;

        data_we     = 1'b0;
        data_waddr  = ptr_eff;
        data_wdata  = din.dat;
        meta_we     = 1'b0;
        meta_waddr  = mix_eff;
        meta_wdata  = {ptr_eff, len_now};
        frame_start = 1'b0;
        frame_good  = 1'b0;
        frame_short = 1'b0;

        if (din.vld) begin
            frame_start = din.sof;
            ptr_d = ptr_eff;
            mix_d = mix_eff;
            unique case (st_eff)
                PS_IDLE: ;
                PS_ID: begin
                    if (din.dat == LIST_END_ID) begin
                        st_d = PS_TAIL;
                    end else begin
                        hit_d = (din.dat == node_id);
                        st_d  = PS_LEN_HI;
                    end
                end
                PS_LEN_HI: begin
                    lhi_d = din.dat;
                    st_d  = PS_LEN_LO;
                end
                PS_LEN_LO: begin
                    rem_d   = len_now;
                    meta_we = hit_q;
                    if (hit_q) mix_d = mix_eff + 1'b1;
                    st_d = (len_now == 16'd0) ? PS_ID : PS_BODY;
                end
                PS_BODY: begin
                    data_we = hit_q;
                    if (hit_q) ptr_d = ptr_eff + 1'b1;
                    rem_d = rem_q - 16'd1;
                    if (rem_q == 16'd1) st_d = PS_ID;
                end
                PS_TAIL: ;
                default: st_d = PS_IDLE;
            endcase
            if (din.eof && st_eff != PS_IDLE) begin
                if (st_d == PS_ID || st_d == PS_TAIL) frame_good = 1'b1;
                else                                  frame_short = 1'b1;
                st_d = PS_IDLE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= PS_IDLE;
            hit_q <= 1'b0;
            lhi_q <= '0;
            rem_q <= '0;
            ptr_q <= '0;
            mix_q <= '0;
        end else begin
            st_q  <= st_d;
            hit_q <= hit_d;
            lhi_q <= lhi_d;
            rem_q <= rem_d;
            ptr_q <= ptr_d;
            mix_q <= mix_d;
        end
    end
endmodule

// File: rtl/sfx_done_timer.sv
module sfx_done_timer #(
    parameter int HOLD = 12,
    localparam int CW = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic frame_start,
    input  logic frame_good,
    input  logic frame_short,
    output logic done_strobe,
    output logic err_flag
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q    <= '0;
            err_flag <= 1'b0;
        end else begin
            if (frame_good)        cnt_q <= CW'(HOLD);
            else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
            if (frame_short)       err_flag <= 1'b1;
            else if (frame_start)  err_flag <= 1'b0;
        end
    end

    assign done_strobe = (cnt_q != '0);
endmodule

// File: rtl/sfx_node_extract.sv
module sfx_node_extract
    import sfx_pkg::*;
#(
    parameter int DATA_AW    = 6,
    parameter int META_AW    = 2,
    parameter int FWD_STAGES = 2,
    parameter int DONE_HOLD  = 12
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [7:0]           node_id,
    input  logic                 in_valid,
    input  logic                 in_sof,
    input  logic                 in_eof,
    input  logic [7:0]           in_data,
    output logic                 out_valid,
    output logic                 out_sof,
    output logic                 out_eof,
    output logic [7:0]           out_data,
    output logic                 done_strobe,
    output logic                 err_flag,
    input  logic [DATA_AW-1:0]   app_rd_addr,
    output logic [7:0]           app_rd_data,
    input  logic [META_AW-1:0]   meta_rd_addr,
    output logic [DATA_AW+15:0]  meta_rd_data
);
    localparam int META_W = DATA_AW + 16;

    beat_t              beat_in, beat_out;
    logic               data_we, meta_we;
    logic [DATA_AW-1:0] data_waddr;
    logic [7:0]         data_wdata;
    logic [META_AW-1:0] meta_waddr;
    logic [META_W-1:0]  meta_wdata;
    logic               frame_start, frame_good, frame_short;

    assign beat_in = '{vld: in_valid, sof: in_sof, eof: in_eof, dat: in_data};

    sfx_fwd_pipe #(.STAGES(FWD_STAGES)) u_fwd (
        .clk(clk), .rst(rst), .din(beat_in), .dout(beat_out)
    );

    assign out_valid = beat_out.vld;
    assign out_sof   = beat_out.sof;
    assign out_eof   = beat_out.eof;
    assign out_data  = beat_out.dat;

    sfx_seg_parser #(.DATA_AW(DATA_AW), .META_AW(META_AW)) u_parse (
        .clk(clk), .rst(rst), .node_id(node_id), .din(beat_in),
        .data_we(data_we), .data_waddr(data_waddr), .data_wdata(data_wdata),
        .meta_we(meta_we), .meta_waddr(meta_waddr), .meta_wdata(meta_wdata),
        .frame_start(frame_start), .frame_good(frame_good), .frame_short(frame_short)
    );

    sfx_dpram #(.AW(DATA_AW), .W(8)) u_app_ram (
        .clk(clk), .we(data_we), .waddr(data_waddr), .wdata(data_wdata),
        .raddr(app_rd_addr), .rdata(app_rd_data)
    );

    sfx_dpram #(.AW(META_AW), .W(META_W)) u_meta_ram (
        .clk(clk), .we(meta_we), .waddr(meta_waddr), .wdata(meta_wdata),
        .raddr(meta_rd_addr), .rdata(meta_rd_data)
    );

    sfx_done_timer #(.HOLD(DONE_HOLD)) u_done (
        .clk(clk), .rst(rst), .frame_start(frame_start), .frame_good(frame_good),
        .frame_short(frame_short), .done_strobe(done_strobe), .err_flag(err_flag)
    );
endmodule

// File: rtl/sfx_node_extract_chk.sv
module sfx_node_extract_chk #(
    parameter int DONE_HOLD = 12
) (
    input logic       clk,
    input logic       rst,
    input logic       in_valid,
    input logic       in_eof,
    input logic [7:0] in_data,
    input logic       out_valid,
    input logic [7:0] out_data,
    input logic       done_strobe,
    input logic       err_flag,
    input logic       data_we,
    input logic       meta_we
);
    logic [1:0] warm_q;
    logic [7:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            warm_q <= '0;
            run_q  <= '0;
        end else begin
            if (warm_q != 2'd2) warm_q <= warm_q + 1'b1;
            run_q <= done_strobe ? run_q + 1'b1 : 8'd0;
        end
    end

    // R1
    fwd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));
    // R1
    fwd_data_chk: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd2 && out_valid) |-> (out_data == $past(in_data, 2)));
    // R7
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_strobe) |-> $past(in_valid && in_eof));
    // R7
    done_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done_strobe) |-> (run_q == 8'(DONE_HOLD)));
    // R7
    done_max_chk: assert property (@(posedge clk) disable iff (rst)
        run_q <= 8'(DONE_HOLD));
    // R8
    err_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(err_flag) |-> ($past(in_valid && in_eof) && !$rose(done_strobe)));
    // R5
    write_needs_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (data_we || meta_we) |-> in_valid);
endmodule

bind sfx_node_extract sfx_node_extract_chk #(.DONE_HOLD(DONE_HOLD)) u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_eof(in_eof), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .done_strobe(done_strobe),
    .err_flag(err_flag), .data_we(data_we), .meta_we(meta_we)
);

// File: tb/sfx_node_extract_tb.sv
module sfx_node_extract_tb;
    localparam int DATA_AW = 6;
    localparam int META_AW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [7:0] node_id = 8'd0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_data = 8'd0;
    logic out_valid, out_sof, out_eof;
    logic [7:0] out_data;
    logic done_strobe, err_flag;
    logic [DATA_AW-1:0] app_rd_addr = '0;
    logic [7:0] app_rd_data;
    logic [META_AW-1:0] meta_rd_addr = '0;
    logic [DATA_AW+15:0] meta_rd_data;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    sfx_node_extract u_dut (
        .clk(clk), .rst(rst), .node_id(node_id), .in_valid(in_valid), .in_sof(in_sof),
        .in_eof(in_eof), .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof),
        .out_eof(out_eof), .out_data(out_data), .done_strobe(done_strobe),
        .err_flag(err_flag), .app_rd_addr(app_rd_addr), .app_rd_data(app_rd_data),
        .meta_rd_addr(meta_rd_addr), .meta_rd_data(meta_rd_data)
    );

    logic [7:0]  fb [64];
    int          flen;
    logic [7:0]  exp_data [64];
    logic [21:0] exp_meta [4];
    int          n_d, n_m;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    // R1 forward monitor: history of the two previous sampled inputs
    logic [10:0] h1 = '0, h2 = '0;
    int warm = 0;
    always @(posedge clk) begin
        h1 <= {in_valid, in_sof, in_eof, in_data};
        h2 <= h1;
        warm <= rst ? 0 : warm + 1;
    end
    always @(negedge clk) begin
        if (!rst && warm >= 2)
            chk("R1 forward", {21'd0, out_valid, out_sof, out_eof, out_data}, {21'd0, h2});
    end

    task automatic push(input logic [7:0] b);
        fb[flen] = b;
        flen++;
    endtask

    task automatic seg(input logic [7:0] id, input int len, input logic [7:0] base);
        push(id);
        push(8'(len >> 8));
        push(8'(len));
        for (int j = 0; j < len; j++) push(base + 8'(j));
    endtask

    function automatic bit model(input logic [7:0] node);
        int i = 0;
        int len;
        n_d = 0;
        n_m = 0;
        while (1) begin
            if (i >= flen) return 1'b1;
            if (fb[i] == 8'hFF) return 1'b1;
            if (i + 2 >= flen) return 1'b0;
            len = {fb[i+1], fb[i+2]};
            if (i + 3 + len > flen) return 1'b0;
            if (fb[i] == node) begin
                exp_meta[n_m] = {6'(n_d), 16'(len)};
                n_m++;
                for (int j = 0; j < len; j++) begin
                    exp_data[n_d] = fb[i+3+j];
                    n_d++;
                end
            end
            i += 3 + len;
        end
    endfunction

    task automatic send();
        for (int i = 0; i < flen; i++) begin
            while ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
            end
            @(negedge clk);
            in_valid = 1'b1;
            in_sof   = (i == 0);
            in_eof   = (i == flen - 1);
            in_data  = fb[i];
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    task automatic read_app(input int a, output logic [7:0] v);
        app_rd_addr = DATA_AW'(a);
        @(negedge clk);
        v = app_rd_data;
    endtask

    task automatic read_meta(input int a, output logic [21:0] v);
        meta_rd_addr = META_AW'(a);
        @(negedge clk);
        v = meta_rd_data;
    endtask

    task automatic run_frame(input string tag);
        bit ok;
        int hi;
        logic [7:0] v;
        logic [21:0] mv;
        ok = model(node_id);
        send();
        // R7 R8: status right after the end byte edge
        chk({tag, " R7 done at end"}, {31'd0, done_strobe}, {31'd0, ok});
        chk({tag, " R8 err at end"}, {31'd0, err_flag}, {31'd0, !ok});
        hi = 0;
        for (int k = 0; k < 16; k++) begin
            if (done_strobe) hi++;
            @(negedge clk);
        end
        chk({tag, " R7 done width"}, 32'(hi), ok ? 32'd12 : 32'd0);
        if (ok) begin
            for (int k = 0; k < n_d; k++) begin
                read_app(k, v);
                chk({tag, " R3 payload"}, {24'd0, v}, {24'd0, exp_data[k]});
            end
            for (int k = 0; k < n_m; k++) begin
                read_meta(k, mv);
                chk({tag, " R4 descriptor"}, {10'd0, mv}, {10'd0, exp_meta[k]});
            end
        end
    endtask

    initial begin
        logic [7:0] v;
        logic [21:0] mv;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        // R2
        chk("R2 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk("R2 reset done", {31'd0, done_strobe}, 32'd0);
        chk("R2 reset err", {31'd0, err_flag}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R2 after reset", {30'd0, done_strobe, err_flag}, 32'd0);

        // R3 R4: two matches among others
        node_id = 8'd3;
        flen = 0;
        seg(8'd1, 2, 8'h10); seg(8'd3, 4, 8'hA0); seg(8'd3, 3, 8'hC0); seg(8'd5, 1, 8'h20);
        push(8'hFF); push(8'h03); push(8'h00);
        run_frame("multi");
        // R10 read latency: address applied, data valid one clock later
        app_rd_addr = 6'd5;
        @(negedge clk);
        chk("R10 read latency", {24'd0, app_rd_data}, 32'hC1);

        // R5 R6: no match, then look-alike after terminator
        flen = 0;
        seg(8'd1, 2, 8'h40); seg(8'd2, 1, 8'h50); push(8'hFF); seg(8'd3, 2, 8'h55);
        run_frame("skip");
        read_app(0, v);
        chk("R5 R6 data kept", {24'd0, v}, 32'hA0);
        read_meta(0, mv);
        chk("R5 R6 descriptor kept", {10'd0, mv}, {10'd0, 6'd0, 16'd4});

        // R6: node id 0xFF never matches
        node_id = 8'hFF;
        flen = 0;
        seg(8'd1, 1, 8'h60); push(8'hFF); push(8'hFF);
        run_frame("ffnode");
        read_app(0, v);
        chk("R6 ff node no write", {24'd0, v}, 32'hA0);

        // R9: zero-length segment then a payload segment
        node_id = 8'd3;
        flen = 0;
        seg(8'd3, 0, 8'h00); seg(8'd3, 2, 8'h70);
        run_frame("zero R9");
        read_meta(0, mv);
        chk("R9 zero length entry", {10'd0, mv}, 32'd0);

        // R8: truncated payload, then header cut, then recovery
        flen = 0;
        seg(8'd3, 5, 8'h30);
        flen = 5;
        run_frame("short body R8");
        chk("R8 err held", {31'd0, err_flag}, 32'd1);
        flen = 0;
        push(8'd3);
        run_frame("short hdr R8");
        flen = 0;
        seg(8'd2, 1, 8'h11); push(8'hFF);
        run_frame("recover R8");

        // random frames
        for (int f = 0; f < 30; f++) begin
            int ns;
            node_id = 8'($urandom_range(1, 6));
            flen = 0;
            ns = $urandom_range(1, 4);
            for (int s = 0; s < ns; s++)
                seg(8'($urandom_range(1, 6)), $urandom_range(0, 5), 8'($urandom_range(0, 255)));
            if ($urandom_range(0, 1) == 1) begin
                push(8'hFF);
                for (int j = 0; j < int'($urandom_range(0, 3)); j++) push(8'($urandom_range(0, 255)));
            end
            if ($urandom_range(0, 4) == 0 && flen > 1) flen = $urandom_range(1, flen - 1);
            run_frame("random R3");
        end

        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule